// File: doc/BRIEF.md
# Programmable Serial Frame Bit Counter

This block keeps track of how many bits of a serial transfer frame have gone by, for a serial port that runs either as a two-wire bus with an acknowledge bit after every data unit or as a plain clocked-serial link without one. Software writes a 3-bit length code that sets how many data bits the next frame carries. The counter then advances on each rising edge of the serial clock, which arrives as a single-cycle strobe in the system clock domain. In two-wire mode it marks the extra acknowledge slot, and it raises a one-cycle completion pulse after the last bit of the frame.

The counter returns to its idle code by itself at the end of every frame, and a detected start condition forces it back to idle at any time. A write of a nonzero length is taken only while the serial clock line is low. A nonzero write attempted while the line is high is dropped, and a sticky flag records the attempt. Reading the length field shows how many data bits are still to come in the current frame, modulo 8.

Top module: `frame_bitcount`

## Requirements
- R1: Length code 000 selects 8 data bits, and codes 001 to 111 select 1 to 7 data bits. In clocked-serial mode (twowire_mode = 0) a frame is exactly that many serial clock strobes long.
- R2: In two-wire mode (twowire_mode = 1) a frame is one strobe longer than the data length. Code 000 gives 9 strobes and code 001 gives 2.
- R3: ack_slot is high in two-wire mode after all data strobes of the frame and before the acknowledge strobe. It is never high in clocked-serial mode.
- R4: frame_done is high for exactly the one cycle after the clock edge that takes the final strobe of a frame. At that point the length code has returned to 000 and count_q reads 000.
- R5: After reset, count_q is 000 and ack_slot, frame_done and wr_err are all 0.
- R6: start_det clears the length code and the frame position. It takes priority over a write and over a strobe in the same cycle.
- R7: A write of a nonzero code is accepted only while sck_level is 0, and a write of 000 is accepted at any time. An accepted write loads the code and restarts the frame, and a strobe in the same cycle is not counted.
- R8: A nonzero write made while sck_level is 1 leaves the code and the position unchanged. It sets wr_err, which stays set until reset. A strobe in the same cycle is still counted.
- R9: count_q equals the number of data bits still to come, modulo 8, so 8 remaining reads as 000. It reads 000 during the acknowledge slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck_rise | input | 1 | One-cycle strobe for a rising serial clock edge |
| sck_level | input | 1 | Current level of the serial clock line |
| start_det | input | 1 | One-cycle pulse when a start condition is detected |
| twowire_mode | input | 1 | 1 = two-wire bus with acknowledge bit, 0 = clocked serial |
| wr_en | input | 1 | Write strobe for the length field |
| wr_data | input | 3 | Length code to write |
| count_q | output | 3 | Readback: data bits remaining, modulo 8 |
| ack_slot | output | 1 | High during the acknowledge bit slot |
| frame_done | output | 1 | One-cycle pulse after the final strobe of a frame |
| wr_err | output | 1 | Sticky flag for a nonzero write rejected while the clock was high |

## Verification
The assertions assume that twowire_mode changes only while no frame is in progress, and that sck_rise and start_det are single-cycle pulses sampled on the system clock. The random stimulus changes the mode only when its own reference model shows the frame position at zero. Strobes, starts, writes and clock levels are drawn independently, so every priority collision can occur. Directed cases cover the shortest and longest frames in both modes, accepted and rejected writes, and a start in the middle of a frame.

// File: rtl/fbc_pkg.sv
// Package: shared types for the frame bit counter.
// Assumes nothing beyond standard SystemVerilog.
package fbc_pkg;
    typedef enum logic {
        MODE_CLOCKED = 1'b0,
        MODE_TWOWIRE = 1'b1
    } fbc_mode_e;
endpackage

// File: rtl/fbc_wr_qual.sv
// Module: fbc_wr_qual
// Decides whether a length write is taken. A code of zero is always taken,
// and a nonzero code only while the serial clock line is low. A start
// pulse overrides any write. A rejected nonzero write sets a sticky error.
// Assumes wr_en is a one-cycle strobe in the clk domain.
module fbc_wr_qual #(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_det,
    input  logic              wr_en,
    input  logic [CODE_W-1:0] wr_data,
    input  logic              sck_level,
    output logic              wr_accept,
    output logic              wr_err
);
    logic nonzero;
    logic reject;

    // Classify the write attempt in this cycle.
    always_comb begin
        nonzero   = |wr_data;
        wr_accept = wr_en && !start_det && (!nonzero || !sck_level);
        reject    = wr_en && !start_det && nonzero && sck_level;
    end

    // Sticky error flag, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wr_err <= 1'b0;
        else if (reject)
            wr_err <= 1'b1;
    end
endmodule

// File: rtl/fbc_len_reg.sv
// Module: fbc_len_reg
// Holds the programmed length code. Order of precedence: start clears it,
// an accepted write loads it, and the end of a frame clears it.
// Assumes frame_end is already qualified against start and write.
module fbc_len_reg #(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_det,
    input  logic              wr_accept,
    input  logic [CODE_W-1:0] wr_data,
    input  logic              frame_end,
    output logic [CODE_W-1:0] code
);
    // Length code register with auto-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            code <= '0;
        else if (start_det)
            code <= '0;
        else if (wr_accept)
            code <= wr_data;
        else if (frame_end)
            code <= '0;
    end
endmodule

// File: rtl/fbc_pos_ctr.sv
// Module: fbc_pos_ctr
// Counts the serial clock strobes of the current frame. The frame length is
// data_len, plus one when two-wire mode adds the acknowledge bit. On the
// final strobe it wraps to zero and raises frame_done for one cycle.
// Assumes data_len is 1..2**CODE_W and twowire is steady within a frame.
module fbc_pos_ctr #(
    parameter int CODE_W = 3,
    parameter int POS_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_det,
    input  logic             wr_accept,
    input  logic             sck_rise,
    input  logic             twowire,
    input  logic [POS_W-1:0] data_len,
    output logic [POS_W-1:0] pos,
    output logic             frame_end,
    output logic             frame_done
);
    logic [POS_W-1:0] frame_len;
    logic             last_bit;

    // Frame length and final-strobe detection.
    always_comb begin
        frame_len = data_len + {{(POS_W-1){1'b0}}, twowire};
        last_bit  = sck_rise && (pos == frame_len - POS_W'(1));
        frame_end = last_bit && !start_det && !wr_accept;
    end

    // Position counter and registered completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos        <= '0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            if (start_det || wr_accept) begin
                pos <= '0;
            end else if (sck_rise) begin
                if (last_bit) begin
                    pos        <= '0;
                    frame_done <= 1'b1;
                end else begin
                    pos <= pos + POS_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/frame_bitcount.sv
// Module: frame_bitcount (top)
// Serial frame bit counter with a programmable data length and an optional
// acknowledge bit. It joins write qualification, the length register and
// the position counter, and decodes the readback and acknowledge slot.
// Assumes all inputs are synchronous to clk and that strobes last one cycle.
module frame_bitcount #(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_rise,
    input  logic              sck_level,
    input  logic              start_det,
    input  logic              twowire_mode,
    input  logic              wr_en,
    input  logic [CODE_W-1:0] wr_data,
    output logic [CODE_W-1:0] count_q,
    output logic              ack_slot,
    output logic              frame_done,
    output logic              wr_err
);
    import fbc_pkg::*;

    localparam int MAX_DATA = 1 << CODE_W;
    localparam int POS_W    = $clog2(MAX_DATA + 2);
    localparam logic [POS_W-1:0] FULL_LEN = POS_W'(MAX_DATA);

    fbc_mode_e         mode;
    logic              wr_accept;
    logic              frame_end;
    logic [CODE_W-1:0] code;
    logic [POS_W-1:0]  pos;
    logic [POS_W-1:0]  data_len;

    // Mode decode from the plain input pin.
    always_comb mode = fbc_mode_e'(twowire_mode);

    fbc_wr_qual #(.CODE_W(CODE_W)) u_wr_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_det (start_det),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .sck_level (sck_level),
        .wr_accept (wr_accept),
        .wr_err    (wr_err)
    );

    fbc_len_reg #(.CODE_W(CODE_W)) u_len_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_det (start_det),
        .wr_accept (wr_accept),
        .wr_data   (wr_data),
        .frame_end (frame_end),
        .code      (code)
    );

    // Code to data length: zero means the full width.
    always_comb begin
        if (code == '0)
            data_len = FULL_LEN;
        else
            data_len = {{(POS_W-CODE_W){1'b0}}, code};
    end

    fbc_pos_ctr #(.CODE_W(CODE_W), .POS_W(POS_W)) u_pos_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_det  (start_det),
        .wr_accept  (wr_accept),
        .sck_rise   (sck_rise),
        .twowire    (mode == MODE_TWOWIRE),
        .data_len   (data_len),
        .pos        (pos),
        .frame_end  (frame_end),
        .frame_done (frame_done)
    );

    // Readback of remaining data bits (mod 2**CODE_W) and ack slot decode.
    always_comb begin
        if (pos < data_len)
            count_q = data_len[CODE_W-1:0] - pos[CODE_W-1:0];
        else
            count_q = '0;
        ack_slot = (mode == MODE_TWOWIRE) && (pos == data_len);
    end
endmodule

// File: rtl/fbc_checker.sv
// Module: fbc_checker
// Property checks on the frame bit counter ports, bound to the top.
// Assumes twowire_mode is steady within a frame.
module fbc_checker #(
    parameter int CODE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sck_rise,
    input logic              sck_level,
    input logic              start_det,
    input logic              twowire_mode,
    input logic              wr_en,
    input logic [CODE_W-1:0] wr_data,
    input logic [CODE_W-1:0] count_q,
    input logic              ack_slot,
    input logic              frame_done,
    input logic              wr_err
);
    // R6
    start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (count_q == '0 && !ack_slot && !frame_done));

    // R4
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (count_q == '0 && !ack_slot));

    // R4
    done_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> $past(sck_rise));

    // R3
    no_ack_clocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !twowire_mode |-> !ack_slot);

    // R9
    ack_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_slot |-> count_q == '0);

    // R8
    reject_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data != '0 && sck_level && !start_det && !sck_rise)
        |=> ($stable(count_q) && wr_err));

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |=> wr_err);
endmodule

bind frame_bitcount fbc_checker #(.CODE_W(CODE_W)) u_fbc_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .sck_rise     (sck_rise),
    .sck_level    (sck_level),
    .start_det    (start_det),
    .twowire_mode (twowire_mode),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .count_q      (count_q),
    .ack_slot     (ack_slot),
    .frame_done   (frame_done),
    .wr_err       (wr_err)
);

// File: tb/tb_frame_bitcount.sv
module tb_frame_bitcount;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck_rise = 1'b0;
    logic       sck_level = 1'b0;
    logic       start_det = 1'b0;
    logic       twowire_mode = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_data = 3'd0;
    logic [2:0] count_q;
    logic       ack_slot;
    logic       frame_done;
    logic       wr_err;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // Reference model state
    int m_code = 0;
    int m_pos = 0;
    bit m_done = 1'b0;
    bit m_err = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    frame_bitcount dut (
        .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .sck_level(sck_level),
        .start_det(start_det), .twowire_mode(twowire_mode), .wr_en(wr_en),
        .wr_data(wr_data), .count_q(count_q), .ack_slot(ack_slot),
        .frame_done(frame_done), .wr_err(wr_err)
    );

    function automatic int dlen(int code);
        return (code == 0) ? 8 : code;
    endfunction

    function automatic int exp_count();
        if (m_pos < dlen(m_code)) return (dlen(m_code) - m_pos) % 8;
        return 0;
    endfunction

    function automatic bit exp_ack();
        return twowire_mode && (m_pos == dlen(m_code));
    endfunction

    task automatic chk(input string tag, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    // Model one clock edge with the inputs currently driven.
    task automatic model_edge();
        m_done = 1'b0;
        if (start_det) begin
            m_code = 0; m_pos = 0;
        end else if (wr_en && (wr_data == 0 || !sck_level)) begin
            m_code = wr_data; m_pos = 0;
        end else begin
            if (wr_en) m_err = 1'b1;
            if (sck_rise) begin
                if (m_pos == dlen(m_code) + int'(twowire_mode) - 1) begin
                    m_pos = 0; m_code = 0; m_done = 1'b1;
                end else begin
                    m_pos++;
                end
            end
        end
    endtask

    // One cycle: drive at negedge, model the posedge, compare at next negedge.
    task automatic step(input bit st, input bit we, input logic [2:0] wd,
                        input bit rise, input bit lvl);
        start_det = st; wr_en = we; wr_data = wd; sck_rise = rise; sck_level = lvl;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        start_det = 1'b0; wr_en = 1'b0; sck_rise = 1'b0;
        chk("R9 count_q", count_q, exp_count());
        chk("R3 ack_slot", ack_slot, exp_ack());
        chk("R4 frame_done", frame_done, m_done);
        chk("R8 wr_err", wr_err, m_err);
    endtask

    task automatic strobes(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 3'd0, 1, 1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        int seed;
        seed = $urandom(32'h5EED_0042);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R5 reset state
        chk("R5 count_q", count_q, 0);
        chk("R5 ack_slot", ack_slot, 0);
        chk("R5 frame_done", frame_done, 0);
        chk("R5 wr_err", wr_err, 0);

        // R2: two-wire, code 000 -> 9 strobes, ack after 8
        twowire_mode = 1'b1;
        strobes(8);
        chk("R3 ack at slot", ack_slot, 1);
        chk("R2 no done before ack", frame_done, 0);
        strobes(1);
        chk("R2 done after 9", frame_done, 1);

        // R2: two-wire, code 001 -> 2 strobes
        step(0, 1, 3'd1, 0, 0);
        chk("R7 write low taken", count_q, 1);
        strobes(1);
        chk("R3 ack code1", ack_slot, 1);
        strobes(1);
        chk("R2 done after 2", frame_done, 1);

        // R1: clocked, code 011 -> 3 strobes
        twowire_mode = 1'b0;
        step(0, 1, 3'd3, 0, 0);
        strobes(2);
        chk("R1 remaining 1", count_q, 1);
        strobes(1);
        chk("R1 done after 3", frame_done, 1);
        chk("R4 code back to 000", count_q, 0);

        // R1: clocked, code 000 -> 8 strobes
        strobes(7);
        chk("R1 not done at 7", frame_done, 0);
        strobes(1);
        chk("R1 done at 8", frame_done, 1);

        // R7: zero write with clock high accepted, no error
        strobes(2);
        step(0, 1, 3'd0, 0, 1);
        chk("R7 zero write restarts", count_q, 0);
        chk("R7 no error", wr_err, 0);

        // R7: accepted write drops same-cycle strobe
        step(0, 1, 3'd5, 1, 0);
        chk("R7 strobe ignored", count_q, 5);

        // R8: nonzero write while high rejected, strobe still counts
        step(0, 1, 3'd2, 1, 1);
        chk("R8 strobe counted", count_q, 4);
        chk("R8 error set", wr_err, 1);

        // R6: start mid-frame wins over write and strobe
        step(1, 1, 3'd6, 1, 0);
        chk("R6 start clears", count_q, 0);

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            if (m_pos == 0 && ($urandom % 10) == 0) twowire_mode = $urandom % 2;
            if (($urandom % 500) == 0) begin
                rst_n = 1'b0;
                @(negedge clk);
                rst_n = 1'b1;
                m_code = 0; m_pos = 0; m_done = 0; m_err = 0;
            end
            step(($urandom % 40) == 0, ($urandom % 16) == 0, 3'($urandom),
                 ($urandom % 3) == 0, $urandom % 2);
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule